// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is a programmable logic cell of the kind found in the logic fabric of a field-programmable array. Four small truth-table memories, each sixteen one-bit words deep, are addressed by the same four low input variables. Their outputs meet in a cofactor-selection stage. That stage uses one or two further input variables as multiplexer selects, which is Shannon expansion. The cell can therefore realize any Boolean function of four, five or six variables.

The truth tables, a width mode and an output-style bit are loaded through a serial configuration chain. A D flip-flop with a clock enable can capture the selected function value. An output multiplexer then presents either the combinational value or the registered one. While the chain is being loaded, the output is forced low so that half-written tables never reach the fabric.

Top module: `lut_cell`

## Requirements
- R1: Each table holds 16 one-bit words. Input bits in_vars[3:0] = {d,c,b,a} form the address k, and the table returns its word k, so an all-zero address reads word 0. In the configuration word, table t word k sits at bit t*16+k.
- R2: The configuration word is 67 bits wide. Bits [66:65] hold the mode, bit 64 selects a registered output when 1, and bits [63:0] hold the tables. The word is shifted in most significant bit first from cfg_din, one bit on each rising clk edge on which cfg_en is 1.
- R3: While cfg_en is 1, y is 0.
- R4: Mode 2'b00 is four-input operation. y follows table 0 at address in_vars[3:0], and in_vars[5:4] have no effect.
- R5: Mode 2'b01 is five-input operation. in_vars[4] = 0 selects table 0 and in_vars[4] = 1 selects table 1. in_vars[5] has no effect.
- R6: Modes 2'b10 and 2'b11 are six-input operation. The value {in_vars[5], in_vars[4]} picks table 0, 1, 2 or 3, so y equals configuration bit in_vars[5:0].
- R7: With the output-select bit at 0, y is the function value of the present inputs with no clock latency.
- R8: With the output-select bit at 1, y is a flip-flop. On a rising clk edge where ce is 1 it takes the function value, and when ce is 0 it holds its value.
- R9: A synchronous active-high rst clears the flip-flop and the whole configuration word. Afterwards y is 0 for every input.
- R10: When cfg_en is 0 the configuration is retained, whatever cfg_din does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the output flip-flop |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain; forces y low |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| ce | input | 1 | Clock enable of the output flip-flop |
| in_vars | input | 6 | Logic inputs {f,e,d,c,b,a} |
| y | output | 1 | Cell output, combinational or registered |

## Verification
The bench loads majority and three-input parity into table 0, and fills the other tables with the complement. A design that let in_vars[5:4] steer the mux in four-input mode would then show inverted values in the exhaustive sweep. Five- and six-input sweeps over fixed pseudo-random tables expose a swapped cofactor order or a reversed shift direction, because the tables would read back permuted. The registered path is checked for exactly one edge of latency and for holding when ce is low, with the next input chosen so that its value differs from the held one. The output is watched during every load, and reset is shown to wipe the tables rather than only the flip-flop.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    localparam int LUT_K     = 4;
    localparam int TBL_DEPTH = 1 << LUT_K;
    localparam int NUM_TBL   = 4;
    localparam int SEL_W     = $clog2(NUM_TBL);
    localparam int NUM_VARS  = LUT_K + SEL_W;
    localparam int TBL_BITS  = NUM_TBL * TBL_DEPTH;
    localparam int MODE_W    = 2;
    localparam int CFG_W     = TBL_BITS + MODE_W + 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_IN4  = 2'b00,
        MODE_IN5  = 2'b01,
        MODE_IN6  = 2'b10,
        MODE_IN6B = 2'b11
    } lut_mode_e;

    // Packed layout: mode in the top bits, then output select, then tables.
    typedef struct packed {
        lut_mode_e             mode;
        logic                  use_reg;
        logic [TBL_BITS-1:0]   tbl;
    } cell_cfg_t;

    // Which cofactor table the upper variables select in a given mode.
    function automatic logic [SEL_W-1:0] table_pick(input lut_mode_e m,
                                                    input logic [SEL_W-1:0] hi);
        logic [SEL_W-1:0] r;
        case (m)
            MODE_IN4: r = '0;
            MODE_IN5: r = {{(SEL_W-1){1'b0}}, hi[0]};
            default:  r = hi;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain
    import lut_cell_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic [W-1:0] cfg_bits
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (cfg_en)
            sr <= {sr[W-2:0], cfg_din};
    end

    assign cfg_bits = sr;

    // R2: each enabled edge moves the chain by one place and enters the new bit at the bottom
    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (sr[0] == $past(cfg_din)) && (sr[W-1:1] == $past(sr[W-2:0])));

    // R10: configuration is retained while not shifting
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(sr));

    // R9: reset empties the chain
    a_r9_cfg_clear: assert property (@(posedge clk)
        rst |=> (sr == '0));

endmodule

// File: rtl/lut_table.sv
module lut_table #(
    parameter int K = 4,
    localparam int DEPTH = 1 << K
) (
    input  logic [DEPTH-1:0] bits,
    input  logic [K-1:0]     addr,
    output logic             q
);

    assign q = bits[addr];

endmodule

// File: rtl/lut_shannon_mux.sv
module lut_shannon_mux
    import lut_cell_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  lut_mode_e          mode,
    input  logic [NUM_TBL-1:0] tbl_q,
    input  logic [SEL_W-1:0]   hi,
    output logic               f
);

    logic [SEL_W-1:0] pick;

    assign pick = table_pick(mode, hi);
    assign f    = tbl_q[pick];

    // R5: in five-input mode the top variable plays no part in the result
    a_r5_top_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IN5 && hi[0] == 1'b0) |-> (f == tbl_q[0]));

    // R4: four-input mode reads only table 0
    a_r4_table0_only: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IN4) |-> (f == tbl_q[0]));

endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic use_reg,
    input  logic quiet,
    input  logic d,
    output logic y
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ce)
            q <= d;
    end

    assign y = quiet ? 1'b0 : (use_reg ? q : d);

    // R8: the flip-flop takes the function value one edge later when enabled
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q == $past(d)));

    // R8: the flip-flop holds without clock enable
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));

    // R9: reset clears the flip-flop
    a_r9_ff_clear: assert property (@(posedge clk)
        rst |=> (q == 1'b0));

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_din,
    input  logic                ce,
    input  logic [NUM_VARS-1:0] in_vars,
    output logic                y
);

    logic [CFG_W-1:0]   cfg_bits;
    cell_cfg_t          cfg;
    logic [NUM_TBL-1:0] tbl_q;
    logic               f_val;

    lut_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_bits (cfg_bits)
    );

    assign cfg = cell_cfg_t'(cfg_bits);

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        lut_table #(.K(LUT_K)) u_tbl (
            .bits (cfg.tbl[t*TBL_DEPTH +: TBL_DEPTH]),
            .addr (in_vars[LUT_K-1:0]),
            .q    (tbl_q[t])
        );
    end

    lut_shannon_mux u_mux (
        .clk   (clk),
        .rst   (rst),
        .mode  (cfg.mode),
        .tbl_q (tbl_q),
        .hi    (in_vars[NUM_VARS-1:LUT_K]),
        .f     (f_val)
    );

    lut_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .use_reg (cfg.use_reg),
        .quiet   (cfg_en),
        .d       (f_val),
        .y       (y)
    );

endmodule

// File: tb/lut_cell_tb_top.sv
`timescale 1ns/1ps
module lut_cell_tb_top;

    localparam int CW = 67;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       ce = 1'b0;
    logic [5:0] in_vars = '0;
    logic       y;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lut_cell dut_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .ce      (ce),
        .in_vars (in_vars),
        .y       (y)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: y=%b expected %b (in_vars=%b)", req, act, exp, in_vars);
        end
    endtask

    // Expected value from the requirement text: mode picks how many variables index the tables.
    function automatic logic expect_f(input logic [CW-1:0] w, input logic [5:0] v);
        logic [5:0] idx;
        case (w[66:65])
            2'b00:   idx = {2'b00, v[3:0]};
            2'b01:   idx = {1'b0, v[4:0]};
            default: idx = v;
        endcase
        return w[idx];
    endfunction

    // Load a configuration word MSB first and watch the output stay low (R2, R3).
    task automatic load(input logic [CW-1:0] w);
        for (int i = CW - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = w[i];
            in_vars = 6'(i);
            #0.5;
            check("R3", y, 1'b0);
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic sweep_comb(input string req, input logic [CW-1:0] w);
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            in_vars = 6'(v);
            #0.5;
            check(req, y, expect_f(w, 6'(v)));
        end
    endtask

    function automatic logic [CW-1:0] make_word(input logic [1:0] mode, input logic use_reg,
                                                input logic [63:0] tbl);
        return {mode, use_reg, tbl};
    endfunction

    initial begin
        logic [15:0] maj, par;
        logic [CW-1:0] w;
        logic held;
        logic found;
        for (int k = 0; k < 16; k++) begin
            logic a, b, c;
            a = k[0]; b = k[1]; c = k[2];
            maj[k] = (a & b) | (a & c) | (b & c);
            par[k] = a ^ b ^ c;
        end

        // R9: reset state
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < 64; v += 7) begin
            @(negedge clk);
            in_vars = 6'(v);
            #0.5;
            check("R9", y, 1'b0);
        end

        // R4, R1, R7: majority in table 0, complements elsewhere
        w = make_word(2'b00, 1'b0, {~maj, ~maj, ~maj, maj});
        load(w);
        sweep_comb("R4", w);
        @(negedge clk); in_vars = 6'b000000; #0.5;
        check("R1", y, maj[0]);

        // R4: three-input parity
        w = make_word(2'b00, 1'b0, {~par, ~par, ~par, par});
        load(w);
        sweep_comb("R4", w);

        // R10: toggling cfg_din without enable leaves the tables intact
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cfg_din = i[0];
        end
        sweep_comb("R10", w);

        // R5: five-input function, tables 2/3 hold decoys
        w = make_word(2'b01, 1'b0, 64'h5A5A_C3C3_9E37_79B9);
        load(w);
        sweep_comb("R5", w);

        // R6, R2: six-input functions in both encodings
        w = make_word(2'b10, 1'b0, 64'hD1B5_4A32_D192_ED03);
        load(w);
        sweep_comb("R6", w);
        w = make_word(2'b11, 1'b0, 64'h8F1B_BCDC_6A09_E667);
        load(w);
        sweep_comb("R2", w);

        // R8: registered path, one edge of latency
        w = make_word(2'b10, 1'b1, 64'h3C6E_F372_A54F_F53A);
        load(w);
        ce = 1'b1;
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            in_vars = 6'(v);
            #0.5;
            held = y;
            @(posedge clk);
            #0.5;
            check("R8", y, expect_f(w, 6'(v)));
            if (v > 0) check("R8", held, expect_f(w, 6'(v - 1)));
        end

        // R8: hold when ce is low
        @(negedge clk);
        ce = 1'b0;
        held = y;
        found = 1'b0;
        for (int v = 0; v < 64; v++) begin
            if (!found && expect_f(w, 6'(v)) != held) begin
                found = 1'b1;
                in_vars = 6'(v);
            end
        end
        repeat (3) @(posedge clk);
        #0.5;
        check("R8", y, held);
        ce = 1'b1;

        // R9: reset clears configuration and flip-flop
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ce  = 1'b0;
        sweep_comb("R9", {CW{1'b0}});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule